// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a circular halfword buffer that sits between a host register port and a byte-wide card-side stream. One transfer direction is active at a time. In receive, the card side writes bytes, which are paired into halfwords, and the host drains whole halfwords. In transmit, the host fills halfwords and the card side reads them back one byte at a time. The fill level is compared with two programmable thresholds on every cycle.

A per-direction DMA enable decides how a threshold crossing is reported. When the enable is set, the crossing drives a DMA request line. When it is clear, the crossing sets a status flag for software to poll. Only the threshold that belongs to the active direction can fire. All four indications are flops, evaluated from the registered level, configuration and direction.

Top module: `thr_fifo_dma`

## Requirements
- R1: The buffer holds DEPTH halfwords (32 by default) as a ring, and halfwords leave in the order they entered, including across pointer wrap. `level_o` reports the number of stored halfwords.
- R2: Receive packing and transmit unpacking both take the low byte first.
  - In receive, the first card byte becomes bits 7:0 and the second becomes bits 15:8; the halfword is stored on the second byte.
  - In transmit, `card_rbyte_o` shows bits 7:0 and then bits 15:8; the halfword is removed after its second byte is read.
- R3: A push while `level_o` equals DEPTH is dropped, and the level stays at DEPTH.
- R4: A host pop while the buffer is empty leaves the level and the read pointer unchanged. `host_rdata_o` always shows the slot at the read pointer.
- R5: In receive, when level > almost-full level, `rx_dreq_o` is set if receive DMA is enabled; otherwise `af_flag_o` is set. When level <= almost-full level, both are clear.
- R6: In transmit, when level < almost-empty level, `tx_dreq_o` is set if transmit DMA is enabled; otherwise `ae_flag_o` is set. When level >= almost-empty level, both are clear.
- R7: When no transfer is active and the buffer is empty, all four threshold outputs are clear. A non-empty buffer is still evaluated while no transfer is active.
- R8: Configuration word layout:
  - bit 15 is the receive DMA enable;
  - bits 12:8 are the almost-full level;
  - bit 7 is the transmit DMA enable;
  - bits 4:0 are the almost-empty level;
  - the other bits read back as 0.

  After reset the word reads 16'h1F00 (almost-full level 31, almost-empty level 0, both DMA enables off), the level is 0, and all outputs are 0.
- R9: A configuration write that sets a DMA enable clears the matching status flag on the next clock edge.
- R10: Direction gating. `dir_rx_i`=1 selects receive and `dir_rx_i`=0 selects transmit. Card writes and host pops act only in receive. Host pushes and card reads act only in transmit. In the other direction they have no effect.
- R11: Threshold outputs are registered. They reflect a level change one clock after the edge that changed the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_active_i | input | 1 | A data transfer is in progress |
| dir_rx_i | input | 1 | 1 = receive (card to host), 0 = transmit |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write word |
| cfg_rdata_o | output | 16 | Configuration readback |
| host_push_i | input | 1 | Host halfword write |
| host_wdata_i | input | 16 | Host write data |
| host_pop_i | input | 1 | Host halfword read strobe |
| host_rdata_o | output | 16 | Halfword at the read pointer |
| card_wr_i | input | 1 | Card byte write strobe |
| card_wbyte_i | input | 8 | Card write byte |
| card_rd_i | input | 1 | Card byte read strobe |
| card_rbyte_o | output | 8 | Card read byte |
| level_o | output | CW ($clog2(DEPTH+1), 6 by default) | Stored halfword count |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |
| af_flag_o | output | 1 | Almost-full status flag |
| ae_flag_o | output | 1 | Almost-empty status flag |

## Verification
The bench builds the block with its default DEPTH of 32. This makes the full 32-entry buffer reachable, so the overflow drop can be exercised. It also lets the highest almost-full level (31) fire only when the buffer is completely full. Consecutive table runs leave the read pointer at different offsets, so later fills wrap the ring and confirm ordering across the wrap. The directed cases then cover the empty pop, direction gating, the idle rule and the one-cycle clearing of a flag after a DMA enable is written.

// File: rtl/thr_fifo_pkg.sv
package thr_fifo_pkg;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int THR_W     = 5;
  localparam int RXDMA_BIT = 15;
  localparam int AF_LSB    = 8;
  localparam int TXDMA_BIT = 7;
  localparam int AE_LSB    = 0;

  typedef struct packed {
    logic             rx_dma;
    logic [THR_W-1:0] af_lvl;
    logic             tx_dma;
    logic [THR_W-1:0] ae_lvl;
  } buf_cfg_t;

  localparam buf_cfg_t CFG_RST = '{rx_dma: 1'b0, af_lvl: 5'd31, tx_dma: 1'b0, ae_lvl: 5'd0};

  function automatic buf_cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
    buf_cfg_t c;
    c.rx_dma = w[RXDMA_BIT];
    c.af_lvl = w[AF_LSB +: THR_W];
    c.tx_dma = w[TXDMA_BIT];
    c.ae_lvl = w[AE_LSB +: THR_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_pack(input buf_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RXDMA_BIT]         = c.rx_dma;
    w[AF_LSB +: THR_W]   = c.af_lvl;
    w[TXDMA_BIT]         = c.tx_dma;
    w[AE_LSB +: THR_W]   = c.ae_lvl;
    return w;
  endfunction
endpackage

// File: rtl/tfd_ring.sv
module tfd_ring #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    start_q;
  logic [CW-1:0]    level_q;
  logic [PW-1:0]    wr_idx, start_inc;
  logic [CW:0]      sum_w;
  logic             push_ok, pop_ok;

  assign full_o  = (level_q == CW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[start_q];
  assign level_o = level_q;

  // write slot = (start + level) mod DEPTH
  always_comb begin
    sum_w     = (CW+1)'(start_q) + (CW+1)'(level_q);
    wr_idx    = PW'((sum_w >= (CW+1)'(DEPTH)) ? sum_w - (CW+1)'(DEPTH) : sum_w);
    start_inc = (start_q == PW'(DEPTH - 1)) ? '0 : start_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_ok) begin
      mem_q[wr_idx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      level_q <= '0;
    end else begin
      if (pop_ok) start_q <= start_inc;
      unique case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + CW'(1);
        2'b01:   level_q <= level_q - CW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CW'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (level_q == CW'(DEPTH)));
  p_empty_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> ($stable(start_q) && level_q == '0));
  p_empty_rdata_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> $stable(rdata_o));
endmodule

// File: rtl/tfd_byte_port.sv
module tfd_byte_port
  import thr_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_rx_i,
  input  logic              card_wr_i,
  input  logic [BYTE_W-1:0] card_wbyte_i,
  output logic              push_o,
  output logic [WORD_W-1:0] push_word_o,
  input  logic              card_rd_i,
  input  logic              empty_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [BYTE_W-1:0] card_rbyte_o,
  output logic              pop_o
);
  logic              rx_hi_q, tx_hi_q;
  logic [BYTE_W-1:0] lo_q;
  logic              rx_take, tx_take;

  assign rx_take      = card_wr_i && dir_rx_i;
  assign tx_take      = card_rd_i && !dir_rx_i && !empty_i;
  assign push_o       = rx_take && rx_hi_q;
  assign push_word_o  = {card_wbyte_i, lo_q};
  assign card_rbyte_o = tx_hi_q ? rdata_i[WORD_W-1:BYTE_W] : rdata_i[BYTE_W-1:0];
  assign pop_o        = tx_take && tx_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_hi_q <= 1'b0;
      tx_hi_q <= 1'b0;
      lo_q    <= '0;
    end else begin
      if (rx_take) begin
        rx_hi_q <= !rx_hi_q;
        if (!rx_hi_q) lo_q <= card_wbyte_i;
      end
      if (tx_take) tx_hi_q <= !tx_hi_q;
    end
  end

  p_pop_on_second_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !tx_hi_q);
endmodule

// File: rtl/tfd_level_mon.sv
module tfd_level_mon
  import thr_fifo_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] level_i,
  input  buf_cfg_t      cfg_i,
  input  logic          dir_rx_i,
  input  logic          xfer_i,
  input  logic          cfg_we_i,
  input  logic          wr_rx_dma_i,
  input  logic          wr_tx_dma_i,
  output logic          rx_dreq_o,
  output logic          tx_dreq_o,
  output logic          af_flag_o,
  output logic          ae_flag_o
);
  logic idle, rx_hit, tx_hit;
  logic rx_dreq_d, tx_dreq_d, af_d, ae_d;

  always_comb begin
    idle      = !xfer_i && (level_i == '0);
    rx_hit    = dir_rx_i && (int'(level_i) > int'(cfg_i.af_lvl));
    tx_hit    = !dir_rx_i && (int'(level_i) < int'(cfg_i.ae_lvl));
    rx_dreq_d = !idle && rx_hit && cfg_i.rx_dma;
    tx_dreq_d = !idle && tx_hit && cfg_i.tx_dma;
    // a write enabling DMA wipes the flag at once
    af_d      = !idle && rx_hit && !cfg_i.rx_dma && !(cfg_we_i && wr_rx_dma_i);
    ae_d      = !idle && tx_hit && !cfg_i.tx_dma && !(cfg_we_i && wr_tx_dma_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_dreq_o <= 1'b0;
      tx_dreq_o <= 1'b0;
      af_flag_o <= 1'b0;
      ae_flag_o <= 1'b0;
    end else begin
      rx_dreq_o <= rx_dreq_d;
      tx_dreq_o <= tx_dreq_d;
      af_flag_o <= af_d;
      ae_flag_o <= ae_d;
    end
  end

  p_rx_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dreq_o || af_flag_o) |-> $past(dir_rx_i));
  p_tx_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_dreq_o || ae_flag_o) |-> !$past(dir_rx_i));
  p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && level_i == '0) |=> !(rx_dreq_o || tx_dreq_o || af_flag_o || ae_flag_o));
  p_cfg_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wr_tx_dma_i) |=> !ae_flag_o);
  p_cfg_clear_af_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wr_rx_dma_i) |=> !af_flag_o);
endmodule

// File: rtl/thr_fifo_dma.sv
module thr_fifo_dma
  import thr_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_active_i,
  input  logic              dir_rx_i,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [WORD_W-1:0] cfg_rdata_o,
  input  logic              host_push_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              host_pop_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic              card_wr_i,
  input  logic [BYTE_W-1:0] card_wbyte_i,
  input  logic              card_rd_i,
  output logic [BYTE_W-1:0] card_rbyte_o,
  output logic [CW-1:0]     level_o,
  output logic              rx_dreq_o,
  output logic              tx_dreq_o,
  output logic              af_flag_o,
  output logic              ae_flag_o
);
  buf_cfg_t          cfg_q;
  logic              card_push, card_pop;
  logic [WORD_W-1:0] card_word, ring_rdata;
  logic              ring_push, ring_pop, ring_full, ring_empty;
  logic [WORD_W-1:0] ring_wdata;
  logic              unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata_i[14:13], cfg_wdata_i[6:5], ring_full};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RST;
    else if (cfg_we_i) cfg_q <= cfg_unpack(cfg_wdata_i);
  end
  assign cfg_rdata_o = cfg_pack(cfg_q);

  // direction selects which side fills and which drains
  assign ring_push  = dir_rx_i ? card_push : host_push_i;
  assign ring_wdata = dir_rx_i ? card_word : host_wdata_i;
  assign ring_pop   = dir_rx_i ? host_pop_i : card_pop;
  assign host_rdata_o = ring_rdata;

  tfd_ring #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ring_push),
    .wdata_i (ring_wdata),
    .pop_i   (ring_pop),
    .rdata_o (ring_rdata),
    .level_o (level_o),
    .full_o  (ring_full),
    .empty_o (ring_empty)
  );

  tfd_byte_port u_bytes (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dir_rx_i     (dir_rx_i),
    .card_wr_i    (card_wr_i),
    .card_wbyte_i (card_wbyte_i),
    .push_o       (card_push),
    .push_word_o  (card_word),
    .card_rd_i    (card_rd_i),
    .empty_i      (ring_empty),
    .rdata_i      (ring_rdata),
    .card_rbyte_o (card_rbyte_o),
    .pop_o        (card_pop)
  );

  tfd_level_mon #(.CW(CW)) u_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (level_o),
    .cfg_i       (cfg_q),
    .dir_rx_i    (dir_rx_i),
    .xfer_i      (xfer_active_i),
    .cfg_we_i    (cfg_we_i),
    .wr_rx_dma_i (cfg_wdata_i[RXDMA_BIT]),
    .wr_tx_dma_i (cfg_wdata_i[TXDMA_BIT]),
    .rx_dreq_o   (rx_dreq_o),
    .tx_dreq_o   (tx_dreq_o),
    .af_flag_o   (af_flag_o),
    .ae_flag_o   (ae_flag_o)
  );

  p_dir_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rx_i && host_push_i && !card_wr_i && !host_pop_i) |=> $stable(level_o));
  p_dir_gate_tx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rx_i && card_wr_i && !host_push_i && !card_rd_i) |=> $stable(level_o));
endmodule

// File: tb/thr_fifo_dma_bench.sv
module thr_fifo_dma_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_active_i = 1'b0, dir_rx_i = 1'b0, cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0, cfg_rdata_o;
  logic        host_push_i = 1'b0, host_pop_i = 1'b0;
  logic [15:0] host_wdata_i = '0, host_rdata_o;
  logic        card_wr_i = 1'b0, card_rd_i = 1'b0;
  logic [7:0]  card_wbyte_i = '0, card_rbyte_o;
  logic [5:0]  level_o;
  logic        rx_dreq_o, tx_dreq_o, af_flag_o, ae_flag_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  thr_fifo_dma u_thr_fifo_dma (.*);

  typedef struct packed {
    logic [15:0] cfg;
    logic        rx;
    logic [5:0]  fill;
    logic [3:0]  exp; // {rx_dreq, af_flag, tx_dreq, ae_flag}
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{16'h0300, 1'b1, 6'd4,  4'b0100},  // R5 flag
    '{16'h8300, 1'b1, 6'd4,  4'b1000},  // R5 dma
    '{16'h8300, 1'b1, 6'd3,  4'b0000},  // R5 at level
    '{16'h1F00, 1'b1, 6'd32, 4'b0100},  // R5 full, top level
    '{16'h0005, 1'b0, 6'd4,  4'b0001},  // R6 flag
    '{16'h0085, 1'b0, 6'd4,  4'b0010},  // R6 dma
    '{16'h0085, 1'b0, 6'd5,  4'b0000},  // R6 at level
    '{16'h0000, 1'b0, 6'd0,  4'b0000},  // R6 level 0 never below
    '{16'h0081, 1'b0, 6'd0,  4'b0010},  // R6 empty, active
    '{16'h0000, 1'b1, 6'd1,  4'b0100}   // R5 af level 0
  };

  function automatic logic [15:0] mkword(input int v, input int i);
    return {4'(v), 4'hA, 8'(i * 7 + 3)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic cfg_wr(input logic [15:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic host_push(input logic [15:0] w);
    host_push_i = 1'b1; host_wdata_i = w;
    tick();
    host_push_i = 1'b0;
  endtask

  task automatic card_word_in(input logic [15:0] w);
    card_wr_i = 1'b1; card_wbyte_i = w[7:0];
    tick();
    card_wbyte_i = w[15:8];
    tick();
    card_wr_i = 1'b0;
  endtask

  task automatic host_pop_chk(input logic [15:0] exp, inout int errs);
    #1;
    if (host_rdata_o !== exp) errs++;
    host_pop_i = 1'b1;
    tick();
    host_pop_i = 1'b0;
  endtask

  task automatic card_word_out(input logic [15:0] exp, inout int errs);
    logic [7:0] b0, b1;
    card_rd_i = 1'b1;
    #1 b0 = card_rbyte_o;
    tick();
    #1 b1 = card_rbyte_o;
    tick();
    card_rd_i = 1'b0;
    if ({b1, b0} !== exp) errs++;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int errs;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R8 reset state
    chk("R8 cfg reset", cfg_rdata_o, 16'h1F00);
    chk("R8 level reset", level_o, 0);
    chk("R8 outputs reset", {rx_dreq_o, af_flag_o, tx_dreq_o, ae_flag_o}, 0);

    // R4 pop on empty, then a push lands at the untouched read slot
    dir_rx_i = 1'b1;
    host_pop_i = 1'b1; tick(); host_pop_i = 1'b0;
    chk("R4 level after empty pop", level_o, 0);
    chk("R4 rdata on empty", host_rdata_o, 16'h0000);
    dir_rx_i = 1'b0;
    host_push(16'hBEEF);
    chk("R4 read slot unchanged", host_rdata_o, 16'hBEEF);
    errs = 0;
    card_word_out(16'hBEEF, errs);
    chk("R2 tx byte order", errs, 0);

    // table walk
    xfer_active_i = 1'b1;
    for (int v = 0; v < 10; v++) begin
      cfg_wr(VECS[v].cfg);
      dir_rx_i = VECS[v].rx;
      for (int i = 0; i < int'(VECS[v].fill); i++) begin
        if (VECS[v].rx) card_word_in(mkword(v, i));
        else            host_push(mkword(v, i));
      end
      tick();
      chk("R1 level after fill", level_o, VECS[v].fill);
      chk(VECS[v].rx ? "R5 threshold outputs" : "R6 threshold outputs",
          {rx_dreq_o, af_flag_o, tx_dreq_o, ae_flag_o}, VECS[v].exp);
      errs = 0;
      for (int i = 0; i < int'(VECS[v].fill); i++) begin
        if (VECS[v].rx) host_pop_chk(mkword(v, i), errs);
        else            card_word_out(mkword(v, i), errs);
      end
      chk("R1 R2 data order", errs, 0);
    end

    // R3 overflow drop
    cfg_wr(16'h0000);
    dir_rx_i = 1'b0;
    for (int i = 0; i < 33; i++) host_push(mkword(11, i));
    chk("R3 level stays full", level_o, 32);
    errs = 0;
    for (int i = 0; i < 32; i++) card_word_out(mkword(11, i), errs);
    chk("R3 dropped word absent", errs, 0);
    chk("R3 empty after drain", level_o, 0);

    // R10 direction gating
    card_word_in(16'h1234);
    chk("R10 card write ignored in tx", level_o, 0);
    dir_rx_i = 1'b1;
    host_push(16'h4321);
    chk("R10 host push ignored in rx", level_o, 0);
    card_word_in(16'h5678);
    card_rd_i = 1'b1; tick(); tick(); card_rd_i = 1'b0;
    chk("R10 card read ignored in rx", level_o, 1);
    dir_rx_i = 1'b0;
    host_pop_i = 1'b1; tick(); host_pop_i = 1'b0;
    chk("R10 host pop ignored in tx", level_o, 1);
    dir_rx_i = 1'b1;
    errs = 0;
    host_pop_chk(16'h5678, errs);
    chk("R2 rx byte packing", errs, 0);

    // R11 one-cycle registered response
    cfg_wr(16'h0100);
    card_word_in(16'h0A0B);
    card_word_in(16'h0C0D);
    chk("R11 flag not yet updated", af_flag_o, 0);
    tick();
    chk("R11 flag one cycle later", af_flag_o, 1);
    errs = 0;
    host_pop_chk(16'h0A0B, errs);
    host_pop_chk(16'h0C0D, errs);
    chk("R1 data after R11 test", errs, 0);

    // R9 enabling DMA clears the flag
    dir_rx_i = 1'b0;
    cfg_wr(16'h0005);
    host_push(16'h1111);
    host_push(16'h2222);
    tick();
    chk("R6 ae flag set", ae_flag_o, 1);
    cfg_wr(16'h0085);
    chk("R9 flag cleared by dma enable", ae_flag_o, 0);
    tick();
    chk("R9 dma request follows", tx_dreq_o, 1);

    // R7 idle rule
    cfg_wr(16'h0005);
    xfer_active_i = 1'b0;
    tick(); tick();
    chk("R7 non-empty still evaluated", ae_flag_o, 1);
    errs = 0;
    card_word_out(16'h1111, errs);
    card_word_out(16'h2222, errs);
    chk("R1 data before R7 idle", errs, 0);
    tick(); tick();
    chk("R7 idle empty clears", {rx_dreq_o, af_flag_o, tx_dreq_o, ae_flag_o}, 0);
    xfer_active_i = 1'b1;
    tick(); tick();
    chk("R7 active empty evaluated", ae_flag_o, 1);

    finish_run();
  end
endmodule